// File: doc/BRIEF.md
# Maskable interrupt status controller

This block gathers the interrupt-causing conditions of a two-channel serial controller into one status register and drives a single active-low interrupt request. Seven conditions come from outside as one-cycle event pulses: receiver ready or FIFO full, transmitter ready and break-state change for each channel, and counter terminal count. The eighth condition comes from an internal change-of-state detector that watches four asynchronous input pins. Each condition stays latched until the action that services it, not a write-one-to-clear. That action is reading the receive holding register, writing the transmit holding register, a break-change reset command, a counter stop command, or reading the pin change register. The first four actions reach the block as clear strobes from the channel logic. The last is a read through the block's own register port.

A writable mask register selects which status bits may raise the request. The status register always reads back unmasked. Two state machines sit in the block. The request machine has the states QUIET and RAISED: QUIET goes to RAISED on the transition `pending` (any status bit ANDed with its mask bit is 1), and RAISED goes back to QUIET on `drained` (no such bit). The detector machine walks FILL0 to FILL1 to FILL2 to RUN, one step per clock after reset, so the synchronizer flops fill before any change can be flagged, and then stays in RUN.

Top module: `irq_ctrl`

## Requirements
- R1: While and after reset, status, mask and change register read 0 and irq_n is 1, with all pins held at 0.
- R2: An event pulse sets its status bit at the next clock edge. The bit positions are: bit0 transmit ready ch0, bit1 receive ready ch0, bit2 break change ch0, bit3 counter, bit4 transmit ready ch1, bit5 receive ready ch1, bit6 break change ch1, bit7 pin change. The status register (address 0) reads these bits unmasked.
- R3: irq_n is 0 exactly one clock after a cycle in which (status AND mask) is nonzero, and 1 one clock after a cycle in which it is zero.
- R4: A clear strobe (receive read, transmit write, break reset command, counter stop command) clears only its own status bit at the next edge.
- R5: When an event and the clear of the same bit arrive in the same cycle, the bit ends up set.
- R6: The mask register is written and read at address 1. A bit written 0 stops that condition from driving irq_n while the status bit stays readable as 1.
- R7: A level change on pin i sets change flag i no later than the third clock edge after it, and status bit7 is the OR of the change flags. The change register (address 2) reads the flags in bits 7:4 and the synchronized pin levels in bits 3:0.
- R8: Reading address 2 clears the change flags at that edge. A read of any other address leaves them set.
- R9: Address 3 reads 0, and writes to addresses 0, 2 and 3 leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt | input | 2 | Receive-ready/FIFO-full event per channel |
| tx_evt | input | 2 | Transmit-ready event per channel |
| brk_evt | input | 2 | Break-state change event per channel |
| ct_evt | input | 1 | Counter terminal-count event |
| rx_clr | input | 2 | Receive holding register read strobe per channel |
| tx_clr | input | 2 | Transmit holding register write strobe per channel |
| brk_clr | input | 2 | Break-change reset command per channel |
| ct_clr | input | 1 | Counter stop command |
| pin_in | input | 4 | Asynchronous pins watched for change of state |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The request function is swept over all 128 patterns of the seven event-fed bits against ten masks: zero, all ones and each single bit. This separates a wrong AND/OR reduction from a wrong bit mapping, and the single-bit masks show that each bit gates only its own position. Each clear is applied alone on a full register and also together with its own event, which tells a clear that hits a neighbour bit apart from one that wins over a new event. Each pin is toggled up and down, and the change register is then read back around a status read, which separates clear-on-read from clear-on-any-read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W = 8;
    localparam int NSRC   = 7;
    localparam int NPIN   = 4;
    localparam int ADDR_W = 2;

    localparam int B_TX0  = 0;
    localparam int B_RX0  = 1;
    localparam int B_BRK0 = 2;
    localparam int B_CT   = 3;
    localparam int B_TX1  = 4;
    localparam int B_RX1  = 5;
    localparam int B_BRK1 = 6;

    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] A_CHG  = 2'd2;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

    typedef enum logic [1:0] {
        DET_FILL0,
        DET_FILL1,
        DET_FILL2,
        DET_RUN
    } det_state_e;
endpackage

// File: rtl/pin_change_det.sv
module pin_change_det
    import irqc_pkg::*;
#(
    parameter int W = NPIN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic         rd_clr_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] chg_o
);
    det_state_e   st_q, st_nx;
    logic [W-1:0] sy1_q, sy2_q, prev_q, chg_q, new_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DET_FILL0;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            DET_FILL0: st_nx = DET_FILL1;
            DET_FILL1: st_nx = DET_FILL2;
            DET_FILL2: st_nx = DET_RUN;
            DET_RUN:   st_nx = DET_RUN;
        endcase
    end

    always_comb begin
        new_chg = (st_q == DET_RUN) ? (sy2_q ^ prev_q) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy1_q  <= '0;
            sy2_q  <= '0;
            prev_q <= '0;
            chg_q  <= '0;
        end else begin
            sy1_q  <= pin_i;
            sy2_q  <= sy1_q;
            prev_q <= sy2_q;
            chg_q  <= (chg_q & ~{W{rd_clr_i}}) | new_chg;
        end
    end

    assign level_o = sy2_q;
    assign chg_o   = chg_q;

    // R8: a change-register read with no fresh change empties the flags
    assert_chg_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (new_chg == '0)) |=> (chg_q == '0));
endmodule

// File: rtl/irq_status.sv
module irq_status
    import irqc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         pin_flag_i,
    input  logic         mask_we_i,
    input  logic [N:0]   mask_wdata_i,
    output logic [N:0]   stat_o,
    output logic [N:0]   mask_o
);
    logic [N-1:0] stat_q;
    logic [N:0]   mask_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         stat_q[g] <= 1'b0;
            else if (set_i[g])  stat_q[g] <= 1'b1;
            else if (clr_i[g])  stat_q[g] <= 1'b0;
        end

        assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> stat_q[g]);
        assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !stat_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    assign stat_o = {pin_flag_i, stat_q};
    assign mask_o = mask_q;

    assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_q == $past(mask_wdata_i)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rx_evt,
    input  logic [1:0]        tx_evt,
    input  logic [1:0]        brk_evt,
    input  logic              ct_evt,
    input  logic [1:0]        rx_clr,
    input  logic [1:0]        tx_clr,
    input  logic [1:0]        brk_clr,
    input  logic              ct_clr,
    input  logic [NPIN-1:0]   pin_in,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    logic [NSRC-1:0]   set_v, clr_v;
    logic [DATA_W-1:0] stat, mask;
    logic [NPIN-1:0]   level, chg;
    logic              rd_clr, mask_we, pending;
    irq_state_e        st_q, st_nx;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[B_TX0]  = tx_evt[0];   clr_v[B_TX0]  = tx_clr[0];
        set_v[B_RX0]  = rx_evt[0];   clr_v[B_RX0]  = rx_clr[0];
        set_v[B_BRK0] = brk_evt[0];  clr_v[B_BRK0] = brk_clr[0];
        set_v[B_CT]   = ct_evt;      clr_v[B_CT]   = ct_clr;
        set_v[B_TX1]  = tx_evt[1];   clr_v[B_TX1]  = tx_clr[1];
        set_v[B_RX1]  = rx_evt[1];   clr_v[B_RX1]  = rx_clr[1];
        set_v[B_BRK1] = brk_evt[1];  clr_v[B_BRK1] = brk_clr[1];
    end

    assign rd_clr  = reg_rd && (reg_addr == A_CHG);
    assign mask_we = reg_wr && (reg_addr == A_MASK);

    pin_change_det #(.W(NPIN)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_in),
        .rd_clr_i (rd_clr),
        .level_o  (level),
        .chg_o    (chg)
    );

    irq_status #(.N(NSRC)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (set_v),
        .clr_i        (clr_v),
        .pin_flag_i   (|chg),
        .mask_we_i    (mask_we),
        .mask_wdata_i (reg_wdata),
        .stat_o       (stat),
        .mask_o       (mask)
    );

    always_comb begin
        unique case (reg_addr)
            A_STAT:  reg_rdata = stat;
            A_MASK:  reg_rdata = mask;
            A_CHG:   reg_rdata = {chg, level};
            default: reg_rdata = '0;
        endcase
    end

    assign pending = |(stat & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IRQ_QUIET;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            IRQ_QUIET:  if (pending)  st_nx = IRQ_RAISED;
            IRQ_RAISED: if (!pending) st_nx = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_n = (st_q != IRQ_RAISED);
    end

    assert_irq_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & mask)) |=> !irq_n);
    assert_irq_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat & mask)) |=> irq_n);
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_evt = '0, tx_evt = '0, brk_evt = '0;
    logic       ct_evt = 1'b0;
    logic [1:0] rx_clr = '0, tx_clr = '0, brk_clr = '0;
    logic       ct_clr = 1'b0;
    logic [3:0] pin_in = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .rx_evt(rx_evt), .tx_evt(tx_evt), .brk_evt(brk_evt), .ct_evt(ct_evt),
        .rx_clr(rx_clr), .tx_clr(tx_clr), .brk_clr(brk_clr), .ct_clr(ct_clr),
        .pin_in(pin_in), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // status bit map: 0 tx0, 1 rx0, 2 brk0, 3 ct, 4 tx1, 5 rx1, 6 brk1
    task automatic pulse(input logic [6:0] s, input logic [6:0] c);
        @(negedge clk);
        tx_evt = {s[4], s[0]}; rx_evt = {s[5], s[1]}; brk_evt = {s[6], s[2]}; ct_evt = s[3];
        tx_clr = {c[4], c[0]}; rx_clr = {c[5], c[1]}; brk_clr = {c[6], c[2]}; ct_clr = c[3];
        @(negedge clk);
        tx_evt = '0; rx_evt = '0; brk_evt = '0; ct_evt = 1'b0;
        tx_clr = '0; rx_clr = '0; brk_clr = '0; ct_clr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] masks [10];
        repeat (3) @(negedge clk);
        chk("R1 irq_n in reset", irq_n, 1);
        rst_n = 1'b1;
        rd(2'd0, d); chk("R1 status after reset", d, 0);
        rd(2'd1, d); chk("R1 mask after reset", d, 0);
        rd(2'd2, d); chk("R1 change reg after reset", d, 0);
        chk("R1 irq_n after reset", irq_n, 1);

        // R2 / R4: each source alone, then its own clear
        for (int b = 0; b < 7; b++) begin
            pulse(7'(1 << b), 7'h00);
            rd(2'd0, d); chk("R2 single bit set", d, 8'(1 << b));
            chk("R6 mask zero keeps irq high", irq_n, 1);
            pulse(7'h00, 7'(1 << b));
            rd(2'd0, d); chk("R4 own clear", d, 0);
        end

        // R4: single clear on full register hits only its bit
        for (int b = 0; b < 7; b++) begin
            pulse(7'h7F, 7'h00);
            pulse(7'h00, 7'(1 << b));
            rd(2'd0, d); chk("R4 clear isolates bit", d, 8'(7'h7F & ~(7'(1 << b))));
            pulse(7'h00, 7'h7F);
        end

        // R5: set and clear together
        for (int b = 0; b < 7; b++) begin
            pulse(7'(1 << b), 7'(1 << b));
            rd(2'd0, d); chk("R5 set beats clear", d, 8'(1 << b));
            pulse(7'h00, 7'h7F);
        end

        // R3 sweep over patterns and masks
        masks[0] = 8'h00; masks[1] = 8'hFF;
        for (int k = 0; k < 8; k++) masks[k+2] = 8'(1 << k);
        for (int m = 0; m < 10; m++) begin
            wr(2'd1, masks[m]);
            rd(2'd1, d); chk("R6 mask readback", d, masks[m]);
            for (int p = 0; p < 128; p++) begin
                pulse(7'(p), 7'h00);
                @(negedge clk);
                chk("R3 irq from pattern and mask", irq_n, !(|(7'(p) & masks[m][6:0])));
                rd(2'd0, d); chk("R2 status reads unmasked", d, 8'(p));
                pulse(7'h00, 7'h7F);
                @(negedge clk);
                chk("R3 irq released after clear", irq_n, 1);
            end
        end

        // R6: masking a set bit drops irq, bit stays visible
        wr(2'd1, 8'h08);
        pulse(7'h08, 7'h00);
        @(negedge clk);
        chk("R6 unmasked bit raises irq", irq_n, 0);
        wr(2'd1, 8'hF7);
        @(negedge clk);
        chk("R6 masked bit drops irq", irq_n, 1);
        rd(2'd0, d); chk("R6 status stays set", d, 8'h08);
        pulse(7'h00, 7'h7F);

        // R9: address 3 and ignored writes
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'hFF); wr(2'd2, 8'hFF); wr(2'd3, 8'h00);
        rd(2'd1, d); chk("R9 mask untouched by other writes", d, 8'h5A);
        rd(2'd3, d); chk("R9 address 3 reads zero", d, 0);

        // R7 / R8: pin change detection, rise then fall on each pin
        wr(2'd1, 8'h80);
        for (int i = 0; i < 4; i++) begin
            for (int dir = 0; dir < 2; dir++) begin
                @(negedge clk);
                pin_in[i] = (dir == 0);
                repeat (4) @(negedge clk);
                rd(2'd0, d); chk("R7 status bit7 set", d, 8'h80);
                chk("R8 status read keeps flag (irq)", irq_n, 0);
                #1 d = reg_rdata;
                rd(2'd2, d); chk("R7 change reg flags and levels", d, {4'(1 << i), pin_in});
                @(negedge clk);
                chk("R8 irq released after change read", irq_n, 1);
                rd(2'd2, d); chk("R8 change flags cleared", d, {4'h0, pin_in});
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule